// File: doc/BRIEF.md
# Serial NOR Flash Identify and Read Engine

This block drives the read side of a serial NOR flash over a four-wire SPI link in clock mode 0. After reset it reads the device identity, which is a manufacturer byte and a 16-bit device code. It then searches a constant parameter table for that identity. The matching entry gives the device size, the erase granularities it supports and whether the part has to be moved into or out of 32-bit addressing. When a mode change is needed, the engine sends the one-byte mode command and polls the status register until the busy bit clears. Only then does it report ready.

In the ready state the engine accepts read requests. A request has a byte address and a byte length, and both must be multiples of the 512-byte read sector. Each accepted request becomes a single fast-read transaction: the opcode, the address in 3 or 4 bytes as the table entry dictates, one zero dummy byte, and then the data. Every received data byte leaves on an 8-bit stream with a valid strobe, in address order. If the identity matches no table entry, the engine raises a flag, stops, and answers every read request with an error pulse.

Top module: `sfl_ident_read`

## Requirements
- R1: While reset is held (synchronous, active low), `spi_csn` is 1, `spi_sclk` is 0, and `rdy`, `id_valid`, `unk_dev`, `dout_valid`, `rd_done` and `rd_err` are all 0.
- R2: The first transaction after reset is 4 bytes long. It sends opcode 0x9F and then three filler bytes. The byte received in slot 1 is the manufacturer, and slots 2 and 3 are the device code with the high byte first.
- R3: Once a table match is found, `id_valid` is 1 and stays stable. `media_size` equals the entry's sector count times 65536. `erase_caps` is set from the entry: bit 0 means 4 KiB erase and bit 1 means 32 KiB erase. `addr4b` is 1 exactly when the entry asks for 32-bit addressing.
- R4: An identity with no match sets `unk_dev` and `id_valid`. `rdy` then never rises and chip select stays high. Each cycle of `rd_req` in this state gives a one-cycle `rd_err` pulse.
- R5: An entry that asks for 32-bit addressing causes a one-byte 0xB7 transaction after the identify transaction. Next come repeated 2-byte status transactions (opcode 0x05) until bit 0 of the second byte reads 0. `rdy` rises only after that poll.
- R6: An entry that asks to leave 32-bit addressing sends a one-byte 0xE9 transaction and then polls in the same way. Reads then use 3-byte addresses.
- R7: An accepted read is one chip-select-low transaction made of 0x0B, the address MSB first (4 bytes if `addr4b`, otherwise the low 3 bytes), one 0x00 dummy byte, and `rd_len` data bytes. The data bytes appear on `dout_data` with `dout_valid`, in order, during that transaction.
- R8: In the ready state, a request is rejected with a one-cycle `rd_err` pulse if bits [8:0] of `rd_addr` are nonzero, if bits [8:0] of `rd_len` are nonzero, or if `rd_len` is 0. A rejected request leaves `rdy` at 1 and starts no transaction.
- R9: A request is taken only while `rdy` is 1. While a read is in progress, `rd_req` is ignored: it gives no error, no extra data and no later transaction.
- R10: `rd_done` pulses for one cycle after the last data byte. In that same cycle chip select is high and `rdy` is 1, so a request made in the `rd_done` cycle is accepted.
- R11: SPI runs in mode 0. `spi_sclk` is low whenever `spi_csn` is high, and bits move MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; SPI clock runs at half of it |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read request strobe |
| rd_addr | input | AW (32) | Byte address of the read |
| rd_len | input | LEN_W (16) | Byte count of the read |
| rd_err | output | 1 | One-cycle pulse: request rejected |
| rd_done | output | 1 | One-cycle pulse: read finished |
| rdy | output | 1 | Engine idle and accepting requests |
| dout_valid | output | 1 | Read data byte valid |
| dout_data | output | 8 | Read data byte |
| id_valid | output | 1 | Identification finished |
| unk_dev | output | 1 | Identity not found in the table |
| media_size | output | MW (32) | Device size in bytes |
| erase_caps | output | 2 | bit0: 4 KiB erase, bit1: 32 KiB erase |
| addr4b | output | 1 | Reads use 4-byte addresses |
| spi_csn | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
The finish of one read and the acceptance of the next one can fall in the same cycle. `rd_done` and `rdy` rise together, so a request that arrives while `rd_done` is high must open a new transaction without any lost or duplicated data. The bench waits for the `rd_done` cycle and drives a second request at once. A behavioural flash model recomputes every expected data byte from the address, and each streamed byte is compared against that queue on every clock. The opposite overlap is also tested: a request made in the middle of a read must leave no trace, and this is judged by the error count, the chip-select count and an empty expectation queue.

// File: rtl/sfl_pkg.sv
// Shared types and the constant part table for the flash identify/read engine.
// Assumes table entries are unique in their (manufacturer, device) pair.
package sfl_pkg;

    typedef enum logic [1:0] {
        AM_KEEP   = 2'd0,
        AM_ENTER4 = 2'd1,
        AM_EXIT4  = 2'd2
    } addr_mode_e;

    typedef struct packed {
        logic [7:0]  mfr;
        logic [15:0] dev;
        logic [9:0]  sectors;
        logic [1:0]  erase;
        addr_mode_e  mode;
    } part_ent_t;

    localparam int NUM_PARTS = 5;

    typedef enum logic [2:0] {
        ST_IDENT  = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_MODE   = 3'd2,
        ST_POLL   = 3'd3,
        ST_READY  = 3'd4,
        ST_READ   = 3'd5,
        ST_NOPART = 3'd6
    } eng_state_e;

    // Returns table entry idx; erase bit0 = 4 KiB, bit1 = 32 KiB.
    function automatic part_ent_t part_entry(input int idx);
        part_ent_t e;
        case (idx)
            0:       e = '{8'hC2, 16'h2019, 10'd512, 2'b11, AM_ENTER4};
            1:       e = '{8'hEF, 16'h4018, 10'd256, 2'b01, AM_KEEP};
            2:       e = '{8'h20, 16'h2017, 10'd128, 2'b00, AM_KEEP};
            3:       e = '{8'h1F, 16'h4800, 10'd128, 2'b01, AM_EXIT4};
            4:       e = '{8'hBF, 16'h254A, 10'd64,  2'b11, AM_KEEP};
            default: e = '{8'h00, 16'h0000, 10'd0,   2'b00, AM_KEEP};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/sfl_byte_shifter.sv
// Mode-0 SPI byte shifter: moves one byte MSB first, SCK = clk/2.
// Assumes start is only raised while busy is low; csn is handled by the caller.
module sfl_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi
);
    logic [2:0] bit_q;
    logic [7:0] txsh_q;
    logic [7:0] rxsh_q;

    // Clock toggling, sampling on the rise and shifting on the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            sclk   <= 1'b0;
            bit_q  <= '0;
            txsh_q <= '0;
            rxsh_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    sclk   <= 1'b0;
                    bit_q  <= '0;
                    txsh_q <= tx;
                end
            end else if (!sclk) begin
                sclk   <= 1'b1;
                rxsh_q <= {rxsh_q[6:0], miso};
            end else begin
                sclk <= 1'b0;
                if (bit_q == 3'd7) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    bit_q  <= bit_q + 3'd1;
                    txsh_q <= {txsh_q[6:0], 1'b0};
                end
            end
        end
    end

    assign mosi = txsh_q[7];
    assign rx   = rxsh_q;

endmodule

// File: rtl/sfl_id_lookup.sv
// Sequential search of the constant part table, one entry per clock.
// Assumes the key is stable from the start pulse until done.
module sfl_id_lookup #(
    parameter int N = sfl_pkg::NUM_PARTS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         key_mfr,
    input  logic [15:0]        key_dev,
    output logic               done,
    output logic               hit,
    output sfl_pkg::part_ent_t ent
);
    import sfl_pkg::*;

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic          run_q;
    logic [IW-1:0] idx_q;
    part_ent_t     cur;

    // Entry currently under comparison.
    always_comb cur = part_entry(int'(idx_q));

    // Walk the table until a match or the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            idx_q <= '0;
            done  <= 1'b0;
            hit   <= 1'b0;
            ent   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                run_q <= 1'b1;
                idx_q <= '0;
            end else if (run_q) begin
                if (cur.mfr == key_mfr && cur.dev == key_dev) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                    hit   <= 1'b1;
                    ent   <= cur;
                end else if (idx_q == IW'(N - 1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                    hit   <= 1'b0;
                end else begin
                    idx_q <= idx_q + IW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sfl_ident_read.sv
// Top of the flash identify/read engine. Identifies the part, applies the
// address-mode command, waits for idle, then serves aligned fast reads.
// Assumes a mode-0 flash with status busy flag in bit 0.
module sfl_ident_read #(
    parameter int         AW         = 32,
    parameter int         LEN_W      = 16,
    parameter int         MW         = 32,
    parameter int         RD_SECT_LG = 9,
    parameter int         SECT_LG    = 16,
    parameter logic [7:0] OP_IDENT   = 8'h9F,
    parameter logic [7:0] OP_FREAD   = 8'h0B,
    parameter logic [7:0] OP_ENTER4  = 8'hB7,
    parameter logic [7:0] OP_EXIT4   = 8'hE9,
    parameter logic [7:0] OP_STATUS  = 8'h05
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_addr,
    input  logic [LEN_W-1:0] rd_len,
    output logic             rd_err,
    output logic             rd_done,
    output logic             rdy,
    output logic             dout_valid,
    output logic [7:0]       dout_data,
    output logic             id_valid,
    output logic             unk_dev,
    output logic [MW-1:0]    media_size,
    output logic [1:0]       erase_caps,
    output logic             addr4b,
    output logic             spi_csn,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    import sfl_pkg::*;

    localparam int CW = LEN_W + 1;

    eng_state_e    st;
    logic          csn_q, go_q, lk_start;
    logic [CW-1:0] bidx, total, hdr;
    logic          last, xfer, aligned;
    logic [7:0]    id_mfr, mode_op, tx_byte;
    logic [15:0]   id_dev;
    logic [AW-1:0] ra;
    logic [31:0]   ra_ext;
    logic [LEN_W-1:0] rl;
    logic [2:0]    na;
    logic          shf_busy, shf_done;
    logic [7:0]    shf_rx;
    logic          lk_done, lk_hit;
    part_ent_t     lk_ent;

    sfl_byte_shifter u_shf (
        .clk(clk), .rst_n(rst_n), .start(go_q), .tx(tx_byte), .miso(spi_miso),
        .busy(shf_busy), .done(shf_done), .rx(shf_rx), .sclk(spi_sclk), .mosi(spi_mosi)
    );

    sfl_id_lookup #(.N(NUM_PARTS)) u_lk (
        .clk(clk), .rst_n(rst_n), .start(lk_start), .key_mfr(id_mfr), .key_dev(id_dev),
        .done(lk_done), .hit(lk_hit), .ent(lk_ent)
    );

    // Transaction length and framing per state.
    always_comb begin
        xfer   = (st == ST_IDENT) || (st == ST_MODE) || (st == ST_POLL) || (st == ST_READ);
        na     = addr4b ? 3'd4 : 3'd3;
        hdr    = addr4b ? CW'(6) : CW'(5);
        ra_ext = 32'(ra);
        case (st)
            ST_IDENT: total = CW'(4);
            ST_MODE:  total = CW'(1);
            ST_POLL:  total = CW'(2);
            ST_READ:  total = hdr + CW'(rl);
            default:  total = CW'(1);
        endcase
        last    = (bidx == total - CW'(1));
        aligned = (rd_addr[RD_SECT_LG-1:0] == '0) && (rd_len[RD_SECT_LG-1:0] == '0)
                  && (rd_len != '0);
    end

    // Byte to send in the current slot.
    always_comb begin
        tx_byte = 8'h00;
        case (st)
            ST_IDENT: if (bidx == '0) tx_byte = OP_IDENT;
            ST_MODE:  tx_byte = mode_op;
            ST_POLL:  if (bidx == '0) tx_byte = OP_STATUS;
            ST_READ: begin
                if (bidx == '0)
                    tx_byte = OP_FREAD;
                else if (bidx <= CW'(na))
                    tx_byte = ra_ext[{na - bidx[2:0], 3'b000} +: 8];
            end
            default: tx_byte = 8'h00;
        endcase
    end

    // Main sequencer: opens transactions, captures bytes, steps the states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDENT;
            csn_q      <= 1'b1;
            go_q       <= 1'b0;
            lk_start   <= 1'b0;
            bidx       <= '0;
            id_mfr     <= '0;
            id_dev     <= '0;
            mode_op    <= '0;
            ra         <= '0;
            rl         <= '0;
            addr4b     <= 1'b0;
            media_size <= '0;
            erase_caps <= '0;
            id_valid   <= 1'b0;
            unk_dev    <= 1'b0;
            dout_valid <= 1'b0;
            dout_data  <= '0;
            rd_done    <= 1'b0;
            rd_err     <= 1'b0;
        end else begin
            go_q       <= 1'b0;
            lk_start   <= 1'b0;
            dout_valid <= 1'b0;
            rd_done    <= 1'b0;
            rd_err     <= 1'b0;
            if (xfer && csn_q && !go_q && !shf_busy) begin
                csn_q <= 1'b0;
                go_q  <= 1'b1;
                bidx  <= '0;
            end else if (xfer && shf_done) begin
                if (st == ST_IDENT) begin
                    if (bidx == CW'(1)) id_mfr       <= shf_rx;
                    if (bidx == CW'(2)) id_dev[15:8] <= shf_rx;
                    if (bidx == CW'(3)) id_dev[7:0]  <= shf_rx;
                end
                if (st == ST_READ && bidx >= hdr) begin
                    dout_valid <= 1'b1;
                    dout_data  <= shf_rx;
                end
                if (last) begin
                    csn_q <= 1'b1;
                    case (st)
                        ST_IDENT: begin
                            st       <= ST_LOOKUP;
                            lk_start <= 1'b1;
                        end
                        ST_MODE:  st <= ST_POLL;
                        ST_POLL:  if (!shf_rx[0]) st <= ST_READY;
                        default: begin
                            st      <= ST_READY;
                            rd_done <= 1'b1;
                        end
                    endcase
                end else begin
                    bidx <= bidx + CW'(1);
                    go_q <= 1'b1;
                end
            end
            case (st)
                ST_LOOKUP: if (lk_done) begin
                    id_valid <= 1'b1;
                    if (lk_hit) begin
                        media_size <= MW'(lk_ent.sectors) << SECT_LG;
                        erase_caps <= lk_ent.erase;
                        case (lk_ent.mode)
                            AM_ENTER4: begin
                                mode_op <= OP_ENTER4;
                                addr4b  <= 1'b1;
                                st      <= ST_MODE;
                            end
                            AM_EXIT4: begin
                                mode_op <= OP_EXIT4;
                                addr4b  <= 1'b0;
                                st      <= ST_MODE;
                            end
                            default: st <= ST_READY;
                        endcase
                    end else begin
                        unk_dev <= 1'b1;
                        st      <= ST_NOPART;
                    end
                end
                ST_READY: if (rd_req) begin
                    if (aligned) begin
                        ra <= rd_addr;
                        rl <= rd_len;
                        st <= ST_READ;
                    end else begin
                        rd_err <= 1'b1;
                    end
                end
                ST_NOPART: if (rd_req) rd_err <= 1'b1;
                default: ;
            endcase
        end
    end

    assign spi_csn = csn_q;
    assign rdy     = (st == ST_READY);

endmodule

// File: rtl/sfl_ident_read_chk.sv
// Port-level property checker for sfl_ident_read, attached by bind below.
module sfl_ident_read_chk #(
    parameter int AW         = 32,
    parameter int LEN_W      = 16,
    parameter int MW         = 32,
    parameter int RD_SECT_LG = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic [AW-1:0]    rd_addr,
    input logic [LEN_W-1:0] rd_len,
    input logic             rd_err,
    input logic             rd_done,
    input logic             rdy,
    input logic             dout_valid,
    input logic             id_valid,
    input logic             unk_dev,
    input logic [MW-1:0]    media_size,
    input logic             spi_csn,
    input logic             spi_sclk
);
    logic good_req;
    assign good_req = (rd_addr[RD_SECT_LG-1:0] == '0) && (rd_len[RD_SECT_LG-1:0] == '0)
                      && (rd_len != '0);

    p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_sclk);

    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> spi_csn);

    p_unknown_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        unk_dev |-> (!rdy && spi_csn));

    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && rd_req && !good_req) |=> (rd_err && rdy));

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && rd_req && good_req) |=> (!rdy && !rd_err));

    p_data_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> !$past(spi_csn));

    p_media_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && $past(id_valid)) |-> $stable(media_size));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (rdy && spi_csn));

endmodule

bind sfl_ident_read sfl_ident_read_chk #(
    .AW(AW), .LEN_W(LEN_W), .MW(MW), .RD_SECT_LG(RD_SECT_LG)
) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_err(rd_err), .rd_done(rd_done), .rdy(rdy), .dout_valid(dout_valid),
    .id_valid(id_valid), .unk_dev(unk_dev), .media_size(media_size),
    .spi_csn(spi_csn), .spi_sclk(spi_sclk)
);

// File: tb/sfl_ident_read_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural flash model plus a per-clock comparison of the data stream.
module sfl_ident_read_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [15:0] rd_len = '0;
    logic        rd_err, rd_done, rdy, dout_valid, id_valid, unk_dev, addr4b;
    logic [7:0]  dout_data;
    logic [31:0] media_size;
    logic [1:0]  erase_caps;
    logic        spi_csn, spi_sclk, spi_mosi, spi_miso;

    always #2.5 clk = ~clk;

    sfl_ident_read dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_err(rd_err), .rd_done(rd_done), .rdy(rdy), .dout_valid(dout_valid),
        .dout_data(dout_data), .id_valid(id_valid), .unk_dev(unk_dev),
        .media_size(media_size), .erase_caps(erase_caps), .addr4b(addr4b),
        .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] data_fn(input logic [31:0] a);
        return (a[7:0] ^ a[15:8]) + a[23:16] + (a[31:24] ^ 8'h3C) + 8'h11;
    endfunction

    // ---------------- flash model ----------------
    logic [7:0]  m_mfr = '0;
    logic [15:0] m_dev = '0;
    bit          m_4b = 1'b0;
    int          m_busy = 0;
    int          mb = 0;
    int          mna = 3;
    int          n_cs = 0;
    int          pk, nk, nb;
    logic [7:0]  msh = '0, mop = '0, mdummy = '0, mr;
    logic [31:0] maddr = '0;
    logic        miso_r = 1'b0;
    logic [7:0]  op_log [$];

    assign spi_miso = miso_r;

    always @(negedge spi_csn) begin
        mb = 0;
        msh = '0;
        miso_r = 1'b0;
        n_cs++;
    end

    always @(posedge spi_csn) begin
        if (mop == 8'h05 && m_busy > 0) m_busy--;
    end

    always @(posedge spi_sclk) begin
        if (spi_csn === 1'b0) begin
            msh = {msh[6:0], spi_mosi};
            mb++;
            if (mb % 8 == 0) begin
                pk = mb / 8 - 1;
                if (pk == 0) begin
                    mop = msh;
                    op_log.push_back(msh);
                    mna = m_4b ? 4 : 3;
                    maddr = '0;
                    if (msh == 8'hB7) begin m_4b = 1'b1; m_busy = 3; end
                    if (msh == 8'hE9) begin m_4b = 1'b0; m_busy = 3; end
                end else if (mop == 8'h0B) begin
                    if (pk <= mna) maddr = {maddr[23:0], msh};
                    else if (pk == mna + 1) mdummy = msh;
                end
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (spi_csn === 1'b0) begin
            nk = mb / 8;
            nb = 7 - (mb % 8);
            mr = 8'h00;
            if (nk >= 1) begin
                case (mop)
                    8'h9F: mr = (nk == 1) ? m_mfr : (nk == 2) ? m_dev[15:8] :
                                (nk == 3) ? m_dev[7:0] : 8'h00;
                    8'h05: mr = {7'b0, (m_busy > 0)};
                    8'h0B: if (nk >= mna + 2) mr = data_fn(maddr + 32'(nk - mna - 2));
                    default: mr = 8'h00;
                endcase
            end
            miso_r = mr[nb];
        end
    end

    // ---------------- per-clock stream comparison ----------------
    logic [7:0] exp_q [$];
    int n_done = 0;
    int n_err = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dout_valid) begin
                if (exp_q.size() == 0) chk("R9 unexpected data byte", {56'b0, dout_data}, 64'hFFFF);
                else chk("R7 data byte", {56'b0, dout_data}, {56'b0, exp_q.pop_front()});
            end
            chk("R11 sclk low while deselected", {63'b0, spi_csn & spi_sclk}, 64'd0);
            if (rd_done) n_done++;
            if (rd_err) n_err++;
        end
    end

    // ---------------- tasks ----------------
    task automatic bring_up(input logic [7:0] mf, input logic [15:0] dv, input bit start4);
        m_mfr = mf; m_dev = dv; m_4b = start4; m_busy = 0;
        op_log.delete();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 csn in reset", {63'b0, spi_csn}, 64'd1);
        chk("R1 sclk in reset", {63'b0, spi_sclk}, 64'd0);
        chk("R1 flags in reset", {58'b0, rdy, id_valid, unk_dev, dout_valid, rd_done, rd_err}, 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rdy || unk_dev) break;
        end
    endtask

    task automatic do_read(input logic [31:0] a, input logic [15:0] l, input bit ok,
                           input bit w4, input string req);
        int e0, d0, c0;
        logic [31:0] eff;
        e0 = n_err; d0 = n_done; c0 = n_cs;
        eff = w4 ? a : {8'h00, a[23:0]};
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a; rd_len = l;
        if (ok) for (int i = 0; i < int'(l); i++) exp_q.push_back(data_fn(eff + 32'(i)));
        @(negedge clk);
        rd_req = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            if (n_done != d0 || n_err != e0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        if (ok) begin
            chk({req, " R10 done pulses"}, 64'(n_done - d0), 64'd1);
            chk({req, " R7 single select"}, 64'(n_cs - c0), 64'd1);
            chk({req, " R7 opcode"}, {56'b0, mop}, 64'h0B);
            chk({req, " R7 address"}, {32'b0, maddr}, {32'b0, eff});
            chk({req, " R7 dummy"}, {56'b0, mdummy}, 64'h00);
            chk({req, " R7 all bytes seen"}, 64'(exp_q.size()), 64'd0);
        end else begin
            chk({req, " R8 error pulse"}, 64'(n_err - e0), 64'd1);
            chk({req, " R8 no transaction"}, 64'(n_cs - c0), 64'd0);
            chk({req, " R8 still ready"}, {63'b0, rdy}, 64'd1);
        end
    endtask

    function automatic int count_status();
        int c = 0;
        foreach (op_log[i]) if (op_log[i] == 8'h05) c++;
        return c;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int e0, d0, c0;
        // Part needing 32-bit addressing.
        bring_up(8'hC2, 16'h2019, 1'b0);
        chk("R5 ready after mode entry", {63'b0, rdy}, 64'd1);
        chk("R2 identify opcode first", {56'b0, op_log[0]}, 64'h9F);
        chk("R5 enter opcode", {56'b0, op_log[1]}, 64'hB7);
        chk("R5 status polls until idle", 64'(count_status()), 64'd4);
        chk("R3 media size", {32'b0, media_size}, 64'h0200_0000);
        chk("R3 erase caps", {62'b0, erase_caps}, 64'd3);
        chk("R3 addr4b", {63'b0, addr4b}, 64'd1);
        chk("R3 id_valid", {62'b0, id_valid, unk_dev}, 64'd2);
        do_read(32'h0123_4400, 16'd512, 1'b1, 1'b1, "R7 4-byte");
        do_read(32'h0000_0100, 16'd512, 1'b0, 1'b1, "R8 addr");
        do_read(32'h0000_0200, 16'd300, 1'b0, 1'b1, "R8 len");
        do_read(32'h0000_0200, 16'd0, 1'b0, 1'b1, "R8 zero");

        // R10: request issued in the rd_done cycle.
        e0 = n_err; d0 = n_done; c0 = n_cs;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 32'h0200_0200; rd_len = 16'd512;
        for (int i = 0; i < 512; i++) exp_q.push_back(data_fn(32'h0200_0200 + 32'(i)));
        @(negedge clk);
        rd_req = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (rd_done) break;
        end
        chk("R10 ready with done", {62'b0, rdy, spi_csn}, 64'd3);
        rd_req = 1'b1; rd_addr = 32'h00AB_CC00; rd_len = 16'd1024;
        for (int i = 0; i < 1024; i++) exp_q.push_back(data_fn(32'h00AB_CC00 + 32'(i)));
        @(negedge clk);
        rd_req = 1'b0;
        chk("R10 back-to-back accepted", {63'b0, rdy}, 64'd0);
        // R9: misaligned request mid-read must be ignored.
        repeat (300) @(negedge clk);
        rd_req = 1'b1; rd_addr = 32'h0000_0011; rd_len = 16'd5;
        @(negedge clk);
        rd_req = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            if (n_done - d0 >= 2) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R9 no error for ignored request", 64'(n_err - e0), 64'd0);
        chk("R10 two completions", 64'(n_done - d0), 64'd2);
        chk("R9 two transactions only", 64'(n_cs - c0), 64'd2);
        chk("R7 stream drained", 64'(exp_q.size()), 64'd0);

        // Part using plain 3-byte addressing.
        bring_up(8'hEF, 16'h4018, 1'b0);
        chk("R2 only identify sent", 64'(op_log.size()), 64'd1);
        chk("R3 media size 3b", {32'b0, media_size}, 64'h0100_0000);
        chk("R3 erase caps 3b", {62'b0, erase_caps}, 64'd1);
        chk("R3 addr4b clear", {63'b0, addr4b}, 64'd0);
        do_read(32'h00FF_FE00, 16'd512, 1'b1, 1'b0, "R7 3-byte");

        // Part that must leave 32-bit addressing.
        bring_up(8'h1F, 16'h4800, 1'b1);
        chk("R6 exit opcode", {56'b0, op_log[1]}, 64'hE9);
        chk("R6 status polls", 64'(count_status()), 64'd4);
        chk("R6 ready", {63'b0, rdy}, 64'd1);
        chk("R6 addr4b clear", {63'b0, addr4b}, 64'd0);
        chk("R3 media size exit", {32'b0, media_size}, 64'h0080_0000);
        do_read(32'h0040_0600, 16'd512, 1'b1, 1'b0, "R6 read");

        // Unknown part.
        bring_up(8'h12, 16'h3456, 1'b0);
        repeat (20) @(negedge clk);
        chk("R4 unknown flag", {61'b0, unk_dev, id_valid, rdy}, 64'd6);
        chk("R4 identify only", 64'(op_log.size()), 64'd1);
        e0 = n_err; c0 = n_cs;
        rd_req = 1'b1; rd_addr = 32'h0000_0000; rd_len = 16'd512;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (50) @(negedge clk);
        chk("R4 read refused", 64'(n_err - e0), 64'd1);
        chk("R4 no transaction", 64'(n_cs - c0), 64'd0);
        chk("R4 still not ready", {63'b0, rdy}, 64'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule